// File: doc/BRIEF.md
# Virtual-to-Physical Request Translator and Access Checker

This block accepts one memory request per cycle (a request is taken whenever `req_valid` is high) and, one cycle later, returns either a physical address with a cacheability flag or a fault code with a status vector. Each request carries a virtual address, an access size, the access kind (fetch, read or write), a flag that skips translation, a flag that marks a page-table access, a flag that selects the alternate privilege mode, and the low bit of the requesting PC. When that bit is set, the request comes from privileged code.

The block runs a fixed sequence of checks in a single combinational pass. The sequence covers data alignment, the canonical form of the address, a kernel-only direct-mapped window, and translation through an external TLB. The TLB is looked up in the same cycle through a dedicated port. The sequence then applies per-mode read and write permission masks with fault-on-read and fault-on-write bits, a range check of the physical address, and decoding of the uncached region. Faults are reported as codes only; delivering the exception is left to the surrounding pipeline.

Privilege modes are encoded 0 kernel, 1 executive, 2 supervisor, 3 user. The implemented physical width is 44 bits and pages are 8 KiB.

Top module: `xlate_check`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and is low after reset. When `rsp_fault` is nonzero, `rsp_paddr` is 0 and `rsp_uncached` is 0. When `rsp_fault` is 0 (none), `rsp_status` is 0.
- R2: A read or write (kind 1 or 2; kind 0 is a fetch) whose address ANDed with (size-1) is nonzero gives fault 1 (alignment), with status bit 0 (write) set only for writes. This check takes priority over every other check. Fetches are never checked for alignment. Size is 1, 2, 4 or 8.
- R3: With `req_phys` set, the physical address equals the virtual address. The range and uncached checks (R11, R12) still apply.
- R4: A fetch with `req_priv_pc` set returns the virtual address with bits 1:0 cleared, masked to 44 bits, with no fault and cacheable. A read or write with `req_priv_pc` set uses kernel mode, or `alt_mode` when `req_alt` is set. Any other request uses `cur_mode`.
- R5: Without `req_phys`, an address whose bits 63:43 do not all equal bit 42 gives fault 2 (fetch access violation, status 0) for a fetch. For a read or write it gives fault 5 (data page fault) with status bit 4 (bad address), plus bit 0 for writes.
- R6: An address with bits 47:41 equal to 7'h7E uses the direct window. In a mode other than kernel, a fetch gives fault 2, and a read or write gives fault 4 (data access violation) with status bit 1 (violation), plus bit 0 for writes. In kernel mode the address is masked to 44 bits. Bits 43:40 are then forced to 1 if bit 40 is set; otherwise only bits 39:0 are kept.
- R7: On a TLB miss, a fetch gives fault 3 (fetch page fault, status 0). A read or write gives fault 6, or fault 7 when `req_ptacc` is set, with status bit 5 (miss), plus bit 0 for writes.
- R8: On a TLB hit, the physical address is `tlb_ppn` shifted left by 13 plus address bits 12:0, and a fetch clears bits 1:0. While a request needs translation, `tlb_lookup` is high, `tlb_vpn` carries address bits 63:13 and `tlb_asn` carries `cur_asn`. `tlb_lookup` is low for physical requests.
- R9: On a write hit, if bit [mode] of `tlb_wr_ok` is clear, the result is fault 5 with status bits 0 and 1, plus bit 3 (fault-on-write) when `tlb_fonw` is set. If the permission bit is set and `tlb_fonw` is set, the result is fault 5 with status bits 0 and 3 only.
- R10: On a read hit, if bit [mode] of `tlb_rd_ok` is clear, the result is fault 4 with status bit 1, plus bit 2 (fault-on-read) when `tlb_fonr` is set. Otherwise, if `tlb_fonr` is set, the result is fault 5 with status bit 2 only. A fetch hit checks only `tlb_rd_ok[mode]` and gives fault 2 when it is clear.
- R11: A physical address with any bit above bit 43 set gives fault 8 (machine check, status 0).
- R12: When physical bit 43 is set, bits 42:41 equal to 2'b11 give fault 9 (unimplemented, status 0), and so does any fetch. Otherwise the access is uncached and bits 42:35 are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 treated as read |
| req_phys | input | 1 | Skip translation |
| req_ptacc | input | 1 | Page-table access (selects miss fault 7) |
| req_alt | input | 1 | Use alternate mode for privileged data access |
| req_priv_pc | input | 1 | Low bit of requesting PC (privileged code) |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| cur_asn | input | 8 | Current address-space number |
| tlb_lookup | output | 1 | TLB lookup request |
| tlb_vpn | output | 51 | Virtual page number to look up |
| tlb_asn | output | 8 | Address-space number to look up |
| tlb_hit | input | 1 | TLB hit |
| tlb_ppn | input | 32 | Physical page number of hit |
| tlb_rd_ok | input | 4 | Read/execute permission per mode |
| tlb_wr_ok | input | 4 | Write permission per mode |
| tlb_fonr | input | 1 | Entry faults on read |
| tlb_fonw | input | 1 | Entry faults on write |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_paddr | output | 64 | Physical address (0 on fault) |
| rsp_uncached | output | 1 | Access is uncached |
| rsp_fault | output | 4 | Fault code, 0 for none |
| rsp_status | output | 8 | Fault status bits |

## Verification
The translation path is driven with ordinary canonical addresses, addresses in the direct window with bit 40 clear and set, non-canonical addresses, and physical-mode addresses carrying bit 43 or bits above the implemented width. Together these separate the four ways a physical address is formed and show which of the late range and uncached checks each way reaches. Permission cases sweep the mode against single-bit masks with the fault-on bits on and off, which separates the violation fault from the fault-on fault for both reads and writes. A randomized mix then compares every result against the behavioural model cycle by cycle.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    FLT_NONE      = 4'd0,
    FLT_ALIGN     = 4'd1,
    FLT_I_ACV     = 4'd2,
    FLT_I_PAGE    = 4'd3,
    FLT_D_ACV     = 4'd4,
    FLT_D_PAGE    = 4'd5,
    FLT_D_MISS    = 4'd6,
    FLT_D_MISS_PT = 4'd7,
    FLT_MCHK      = 4'd8,
    FLT_UNIMP     = 4'd9
  } fault_e;

  localparam int ST_W     = 8;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_FONW  = 3;
  localparam int ST_BADVA = 4;
  localparam int ST_MISS  = 5;

  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 1 << MODE_W;
  localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

endpackage

// File: rtl/xlc_rst_sync.sv
module xlc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xlc_align.sv
module xlc_align #(
  parameter int SZ_W = 4
) (
  input  logic [SZ_W-1:0] va_lo,
  input  logic [SZ_W-1:0] size,
  input  logic            is_data,
  output logic            misaligned
);
  logic [SZ_W-1:0] size_mask;

  always_comb begin
    size_mask  = size - SZ_W'(1);
    misaligned = is_data && (|(va_lo & size_mask));
  end
endmodule

// File: rtl/xlc_vmap.sv
module xlc_vmap
  import xlc_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 32,
  parameter int SP_HI      = 47,
  parameter int SP_LO      = 41,
  parameter int SP_TAG     = 126
) (
  input  logic [VA_W-1:0]      va,
  input  logic                 is_fetch,
  input  logic                 is_write,
  input  logic                 priv_pc,
  input  logic                 phys,
  input  logic                 ptacc,
  input  logic                 altflag,
  input  logic [MODE_W-1:0]    cur_mode,
  input  logic [MODE_W-1:0]    alt_mode,
  input  logic                 tlb_hit,
  input  logic [PPN_W-1:0]     tlb_ppn,
  input  logic [NUM_MODES-1:0] rd_ok,
  input  logic [NUM_MODES-1:0] wr_ok,
  input  logic                 fonr,
  input  logic                 fonw,
  output logic                 lookup_need,
  output fault_e               flt,
  output logic [ST_W-1:0]      st,
  output logic [VA_W-1:0]      pa,
  output logic                 bypass
);
  localparam int SIGN_BIT = PA_W - 4;
  localparam int HI_PAD   = VA_W - PA_W;
  localparam int HIT_PAD  = VA_W - PPN_W - PAGE_SHIFT;
  localparam int SP_W     = SP_HI - SP_LO + 1;
  localparam logic [SP_W-1:0] SP_TAG_V = SP_TAG[SP_W-1:0];

  logic [MODE_W-1:0] eff_mode;
  logic              canon;
  logic              in_window;
  logic [VA_W-1:0]   win_pa;
  logic [VA_W-1:0]   hit_pa;
  logic [VA_W-1:0]   priv_fetch_pa;
  logic              perm_ok;
  logic              fon;

  // mode used for checks: privileged data accesses run in kernel or alternate mode
  always_comb begin
    eff_mode = cur_mode;
    if (!is_fetch && priv_pc) eff_mode = altflag ? alt_mode : MODE_KERNEL;
  end

  always_comb begin
    canon     = (&va[VA_W-1:PA_W-2]) || !(|va[VA_W-1:PA_W-2]);
    in_window = (va[SP_HI:SP_LO] == SP_TAG_V);
    if (va[SIGN_BIT])
      win_pa = {{HI_PAD{1'b0}}, {(PA_W-SIGN_BIT){1'b1}}, va[SIGN_BIT-1:0]};
    else
      win_pa = {{(VA_W-SIGN_BIT){1'b0}}, va[SIGN_BIT-1:0]};
    hit_pa        = {{HIT_PAD{1'b0}}, tlb_ppn, va[PAGE_SHIFT-1:2],
                     (is_fetch ? 2'b00 : va[1:0])};
    priv_fetch_pa = {{HI_PAD{1'b0}}, va[PA_W-1:2], 2'b00};
    perm_ok       = is_write ? wr_ok[eff_mode] : rd_ok[eff_mode];
    fon           = is_write ? fonw : fonr;
  end

  // fixed priority of translation checks
  always_comb begin
    flt         = FLT_NONE;
    st          = '0;
    pa          = va;
    bypass      = 1'b0;
    lookup_need = 1'b0;
    if (is_fetch && priv_pc) begin
      pa     = priv_fetch_pa;
      bypass = 1'b1;
    end else if (phys) begin
      pa = va;
    end else if (!canon) begin
      if (is_fetch) begin
        flt = FLT_I_ACV;
      end else begin
        flt          = FLT_D_PAGE;
        st[ST_BADVA] = 1'b1;
        st[ST_WR]    = is_write;
      end
    end else if (in_window) begin
      if (eff_mode != MODE_KERNEL) begin
        if (is_fetch) begin
          flt = FLT_I_ACV;
        end else begin
          flt        = FLT_D_ACV;
          st[ST_ACV] = 1'b1;
          st[ST_WR]  = is_write;
        end
      end else begin
        pa = win_pa;
      end
    end else begin
      lookup_need = 1'b1;
      pa          = hit_pa;
      if (!tlb_hit) begin
        if (is_fetch) begin
          flt = FLT_I_PAGE;
        end else begin
          flt         = ptacc ? FLT_D_MISS_PT : FLT_D_MISS;
          st[ST_MISS] = 1'b1;
          st[ST_WR]   = is_write;
        end
      end else if (is_fetch) begin
        if (!rd_ok[eff_mode]) flt = FLT_I_ACV;
      end else if (!perm_ok) begin
        flt         = is_write ? FLT_D_PAGE : FLT_D_ACV;
        st[ST_WR]   = is_write;
        st[ST_ACV]  = 1'b1;
        st[ST_FONW] = is_write && fonw;
        st[ST_FONR] = !is_write && fonr;
      end else if (fon) begin
        flt         = FLT_D_PAGE;
        st[ST_WR]   = is_write;
        st[ST_FONW] = is_write;
        st[ST_FONR] = !is_write;
      end
    end
  end
endmodule

// File: rtl/xlc_pcheck.sv
module xlc_pcheck
  import xlc_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 44,
  parameter int STRIP_LO = 35
) (
  input  logic [VA_W-1:0] pa_in,
  input  logic            is_fetch,
  output fault_e          flt,
  output logic [VA_W-1:0] pa_out,
  output logic            uncached
);
  localparam int UC_BIT = PA_W - 1;

  logic out_of_range;
  logic uc_region;
  logic reg_space;

  always_comb begin
    out_of_range = |pa_in[VA_W-1:PA_W];
    uc_region    = pa_in[UC_BIT];
    reg_space    = uc_region && (&pa_in[PA_W-2:PA_W-3]);
    pa_out       = pa_in;
    if (uc_region) pa_out[PA_W-2:STRIP_LO] = '0;
    flt      = FLT_NONE;
    uncached = 1'b0;
    if (out_of_range)                flt = FLT_MCHK;
    else if (reg_space)              flt = FLT_UNIMP;
    else if (uc_region && is_fetch)  flt = FLT_UNIMP;
    else                             uncached = uc_region;
  end
endmodule

// File: rtl/xlate_check.sv
module xlate_check
  import xlc_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 32,
  parameter int ASN_W      = 8,
  parameter int SZ_W       = 4,
  parameter int SP_HI      = 47,
  parameter int SP_LO      = 41,
  parameter int SP_TAG     = 126,
  parameter int STRIP_LO   = 35
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [SZ_W-1:0]       req_size,
  input  logic [1:0]            req_kind,
  input  logic                  req_phys,
  input  logic                  req_ptacc,
  input  logic                  req_alt,
  input  logic                  req_priv_pc,
  input  logic [1:0]            cur_mode,
  input  logic [1:0]            alt_mode,
  input  logic [ASN_W-1:0]      cur_asn,
  output logic                  tlb_lookup,
  output logic [VA_W-PAGE_SHIFT-1:0] tlb_vpn,
  output logic [ASN_W-1:0]      tlb_asn,
  input  logic                  tlb_hit,
  input  logic [PPN_W-1:0]      tlb_ppn,
  input  logic [3:0]            tlb_rd_ok,
  input  logic [3:0]            tlb_wr_ok,
  input  logic                  tlb_fonr,
  input  logic                  tlb_fonw,
  output logic                  rsp_valid,
  output logic [VA_W-1:0]       rsp_paddr,
  output logic                  rsp_uncached,
  output logic [3:0]            rsp_fault,
  output logic [ST_W-1:0]       rsp_status
);
  logic rst_sync_n;
  logic is_fetch, is_write, misaligned;
  logic lookup_need, vm_bypass, pc_uc;
  fault_e vm_flt, pc_flt;
  logic [ST_W-1:0] vm_st;
  logic [VA_W-1:0] vm_pa, pc_pa;

  fault_e          nxt_fault;
  logic [ST_W-1:0] nxt_status;
  logic [VA_W-1:0] nxt_paddr;
  logic            nxt_uc;

  fault_e          fault_q;
  logic [ST_W-1:0] status_q;
  logic [VA_W-1:0] paddr_q;
  logic            uc_q;
  logic            valid_q;

  assign is_fetch = (req_kind == KIND_FETCH);
  assign is_write = (req_kind == KIND_WRITE);

  xlc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  xlc_align #(.SZ_W(SZ_W)) u_align (
    .va_lo(req_vaddr[SZ_W-1:0]), .size(req_size),
    .is_data(!is_fetch), .misaligned(misaligned)
  );

  xlc_vmap #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .PPN_W(PPN_W),
    .SP_HI(SP_HI), .SP_LO(SP_LO), .SP_TAG(SP_TAG)
  ) u_vmap (
    .va(req_vaddr), .is_fetch(is_fetch), .is_write(is_write),
    .priv_pc(req_priv_pc), .phys(req_phys), .ptacc(req_ptacc),
    .altflag(req_alt), .cur_mode(cur_mode), .alt_mode(alt_mode),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .rd_ok(tlb_rd_ok),
    .wr_ok(tlb_wr_ok), .fonr(tlb_fonr), .fonw(tlb_fonw),
    .lookup_need(lookup_need), .flt(vm_flt), .st(vm_st),
    .pa(vm_pa), .bypass(vm_bypass)
  );

  xlc_pcheck #(.VA_W(VA_W), .PA_W(PA_W), .STRIP_LO(STRIP_LO)) u_pcheck (
    .pa_in(vm_pa), .is_fetch(is_fetch),
    .flt(pc_flt), .pa_out(pc_pa), .uncached(pc_uc)
  );

  assign tlb_lookup = req_valid && lookup_need;
  assign tlb_vpn    = req_vaddr[VA_W-1:PAGE_SHIFT];
  assign tlb_asn    = cur_asn;

  // next-state: pick the first failing stage
  always_comb begin
    nxt_fault  = FLT_NONE;
    nxt_status = '0;
    nxt_paddr  = '0;
    nxt_uc     = 1'b0;
    if (misaligned) begin
      nxt_fault         = FLT_ALIGN;
      nxt_status[ST_WR] = is_write;
    end else if (vm_flt != FLT_NONE) begin
      nxt_fault  = vm_flt;
      nxt_status = vm_st;
    end else if (vm_bypass) begin
      nxt_paddr = vm_pa;
    end else begin
      nxt_fault = pc_flt;
      nxt_paddr = pc_pa;
      nxt_uc    = pc_uc;
    end
    if (nxt_fault != FLT_NONE) begin
      nxt_paddr = '0;
      nxt_uc    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= req_valid;
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      fault_q  <= nxt_fault;
      status_q <= nxt_status;
      paddr_q  <= nxt_paddr;
      uc_q     <= nxt_uc;
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_fault    = fault_q;
  assign rsp_status   = status_q;
  assign rsp_paddr    = paddr_q;
  assign rsp_uncached = uc_q;
endmodule

// File: rtl/xlate_check_sva.sv
module xlate_check_sva #(
  parameter int VA_W     = 64,
  parameter int PA_W     = 44,
  parameter int SZ_W     = 4,
  parameter int STRIP_LO = 35
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_kind,
  input logic [SZ_W-1:0] req_va_lo,
  input logic [SZ_W-1:0] req_size,
  input logic            rsp_valid,
  input logic [VA_W-1:0] rsp_paddr,
  input logic            rsp_uncached,
  input logic [3:0]      rsp_fault,
  input logic [7:0]      rsp_status
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_fault_zero_pa_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 4'd0) |-> (rsp_paddr == '0 && !rsp_uncached));

  assert_clean_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 4'd0) |-> (rsp_status == 8'd0));

  assert_align_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'd0 && (|(req_va_lo & (req_size - SZ_W'(1)))))
      |=> (rsp_fault == 4'd1));

  assert_pa_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 4'd0) |-> (rsp_paddr[VA_W-1:PA_W] == '0));

  assert_uc_stripped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_uncached) |->
      (rsp_paddr[PA_W-1] && rsp_paddr[PA_W-2:STRIP_LO] == '0));

  assert_no_uc_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_kind) == 2'd0) |-> !rsp_uncached);
endmodule

bind xlate_check xlate_check_sva #(
  .VA_W(VA_W), .PA_W(PA_W), .SZ_W(SZ_W), .STRIP_LO(STRIP_LO)
) u_sva (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_va_lo(req_vaddr[SZ_W-1:0]), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
  .rsp_fault(rsp_fault), .rsp_status(rsp_status)
);

// File: tb/tb_xlate_check.sv
`timescale 1ns/1ps
module tb_xlate_check;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_vaddr;
  logic [3:0]  req_size;
  logic [1:0]  req_kind;
  logic        req_phys, req_ptacc, req_alt, req_priv_pc;
  logic [1:0]  cur_mode, alt_mode;
  logic [7:0]  cur_asn;
  logic        tlb_lookup;
  logic [50:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic        tlb_hit;
  logic [31:0] tlb_ppn;
  logic [3:0]  tlb_rd_ok, tlb_wr_ok;
  logic        tlb_fonr, tlb_fonw;
  logic        rsp_valid;
  logic [63:0] rsp_paddr;
  logic        rsp_uncached;
  logic [3:0]  rsp_fault;
  logic [7:0]  rsp_status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [3:0]  e_fault;
  logic [7:0]  e_st;
  logic [63:0] e_pa;
  logic        e_uc;

  localparam logic [63:0] M44 = 64'h0000_0FFF_FFFF_FFFF;
  localparam logic [63:0] SPW = 64'hFFFF_FC00_0000_0000;

  always #2 clk = ~clk;

  xlate_check dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_size(req_size), .req_kind(req_kind), .req_phys(req_phys),
    .req_ptacc(req_ptacc), .req_alt(req_alt), .req_priv_pc(req_priv_pc),
    .cur_mode(cur_mode), .alt_mode(alt_mode), .cur_asn(cur_asn),
    .tlb_lookup(tlb_lookup), .tlb_vpn(tlb_vpn), .tlb_asn(tlb_asn),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_rd_ok(tlb_rd_ok),
    .tlb_wr_ok(tlb_wr_ok), .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
    .rsp_fault(rsp_fault), .rsp_status(rsp_status)
  );

  // behavioural reference of the check sequence
  function automatic void model();
    logic [63:0] pa;
    logic [63:0] up;
    int  m;
    bit  w, f;
    e_fault = 0; e_st = 0; e_pa = 0; e_uc = 0;
    w = (req_kind == 2'd2);
    f = (req_kind == 2'd0);
    if (!f && ((req_vaddr & (64'(req_size) - 64'd1)) != 0)) begin
      e_fault = 1; e_st = {7'd0, w}; return;
    end
    m = cur_mode;
    if (!f && req_priv_pc) m = req_alt ? int'(alt_mode) : 0;
    if (f && req_priv_pc) begin
      e_pa = (req_vaddr & ~64'h3) & M44; return;
    end
    if (req_phys) pa = req_vaddr;
    else begin
      up = req_vaddr >> 42;
      if (!(up == 64'd0 || up == 64'h3F_FFFF)) begin
        if (f) e_fault = 2;
        else begin e_fault = 5; e_st = 8'h10 | {7'd0, w}; end
        return;
      end
      if (((req_vaddr >> 41) & 64'h7F) == 64'h7E) begin
        if (m != 0) begin
          if (f) e_fault = 2;
          else begin e_fault = 4; e_st = 8'h02 | {7'd0, w}; end
          return;
        end
        pa = req_vaddr & M44;
        if (pa[40]) pa = pa | 64'h0000_0F00_0000_0000;
        else        pa = pa & 64'h0000_00FF_FFFF_FFFF;
      end else begin
        if (!tlb_hit) begin
          if (f) e_fault = 3;
          else begin e_fault = req_ptacc ? 4'd7 : 4'd6; e_st = 8'h20 | {7'd0, w}; end
          return;
        end
        pa = (64'(tlb_ppn) << 13) + (req_vaddr & 64'h1FFF);
        if (f) begin
          pa = pa & ~64'h3;
          if (!tlb_rd_ok[m]) begin e_fault = 2; return; end
        end else if (w) begin
          if (!tlb_wr_ok[m]) begin e_fault = 5; e_st = tlb_fonw ? 8'h0B : 8'h03; end
          else if (tlb_fonw) begin e_fault = 5; e_st = 8'h09; end
        end else begin
          if (!tlb_rd_ok[m]) begin e_fault = 4; e_st = tlb_fonr ? 8'h06 : 8'h02; end
          else if (tlb_fonr) begin e_fault = 5; e_st = 8'h04; end
        end
        if (e_fault != 0) begin e_st = e_st; return; end
      end
    end
    if ((pa >> 44) != 0) begin e_fault = 8; return; end
    if (pa[43]) begin
      if (pa[42:41] == 2'b11 || f) begin e_fault = 9; return; end
      pa   = pa & ~(64'hFF << 35);
      e_uc = 1;
    end
    e_pa = pa;
  endfunction

  task automatic clr();
    req_valid = 0; req_vaddr = 0; req_size = 4'd8; req_kind = 2'd1;
    req_phys = 0; req_ptacc = 0; req_alt = 0; req_priv_pc = 0;
    cur_mode = 0; alt_mode = 0; cur_asn = 8'h00;
    tlb_hit = 0; tlb_ppn = 0; tlb_rd_ok = 4'hF; tlb_wr_ok = 4'hF;
    tlb_fonr = 0; tlb_fonw = 0;
  endtask

  task automatic set_tlb(input logic hit, input logic [31:0] ppn,
                         input logic [3:0] rd, input logic [3:0] wr,
                         input logic fr, input logic fw);
    tlb_hit = hit; tlb_ppn = ppn; tlb_rd_ok = rd; tlb_wr_ok = wr;
    tlb_fonr = fr; tlb_fonw = fw;
  endtask

  // issue one request at a falling edge, compare result one cycle later
  task automatic go(input string tag);
    model();
    req_valid = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    n_checks++;
    if (rsp_valid !== 1'b1 || rsp_fault !== e_fault || rsp_status !== e_st ||
        rsp_paddr !== e_pa || rsp_uncached !== e_uc) begin
      n_fail++;
      $display("FAIL %s: got v=%b flt=%0d st=%h pa=%h uc=%b, expected v=1 flt=%0d st=%h pa=%h uc=%b",
               tag, rsp_valid, rsp_fault, rsp_status, rsp_paddr, rsp_uncached,
               e_fault, e_st, e_pa, e_uc);
    end
    @(posedge clk); @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 pulse after %s: got rsp_valid=%b expected 0", tag, rsp_valid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no completion, expected end of run");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got rsp_valid=%b expected 0", rsp_valid);
    end

    // R2 alignment
    clr(); req_vaddr = 64'h1002; req_size = 4; req_kind = 1; go("R2 misaligned read");
    clr(); req_vaddr = 64'h1004; req_size = 8; req_kind = 2; go("R2 misaligned write");
    clr(); req_vaddr = 64'h1001; req_size = 2; req_kind = 2; req_phys = 1; go("R2 before physical");
    clr(); req_vaddr = 64'h1002; req_size = 8; req_kind = 0; req_phys = 1; go("R2 fetch unchecked");
    clr(); req_vaddr = 64'h1003; req_size = 1; req_kind = 1; req_phys = 1; go("R2 byte any address");

    // R3 physical
    clr(); req_vaddr = 64'h0000_0012_3456_7890; req_phys = 1; go("R3 physical passthrough");
    clr(); req_vaddr = 64'h0000_0012_3456_7890; req_phys = 1; req_kind = 0; go("R3 physical fetch");
    clr(); req_phys = 1; #1;
    n_checks++;
    if (tlb_lookup !== 1'b0) begin
      n_fail++; $display("FAIL R8 lookup on physical: got %b expected 0", tlb_lookup);
    end

    // R4 privileged PC
    clr(); req_kind = 0; req_priv_pc = 1; cur_mode = 3;
    req_vaddr = 64'hFFFF_FFFF_FFFF_F00F; go("R4 privileged fetch");
    clr(); req_priv_pc = 1; req_alt = 1; alt_mode = 3; cur_mode = 0;
    req_vaddr = 64'h2000; set_tlb(1, 32'h10, 4'b0001, 4'hF, 0, 0); go("R4 alternate mode used");
    clr(); req_priv_pc = 1; cur_mode = 3; alt_mode = 3;
    req_vaddr = 64'h2000; set_tlb(1, 32'h10, 4'b0001, 4'hF, 0, 0); go("R4 kernel mode used");
    clr(); cur_mode = 3;
    req_vaddr = 64'h2000; set_tlb(1, 32'h10, 4'b0001, 4'hF, 0, 0); go("R4 current mode used");

    // R5 canonical
    clr(); req_vaddr = 64'h0000_0800_0000_0000; go("R5 noncanonical read");
    clr(); req_vaddr = 64'h0000_0800_0000_0000; req_kind = 2; go("R5 noncanonical write");
    clr(); req_vaddr = 64'hFFFF_F400_0000_0000; req_kind = 0; go("R5 noncanonical fetch");

    // R6 direct window
    clr(); req_vaddr = SPW | 64'h0012_3456_7800; go("R6 window bit40 clear");
    clr(); req_vaddr = SPW | 64'h0100_0000_1000; go("R6 window bit40 set");
    clr(); req_vaddr = SPW | 64'h40; cur_mode = 3; go("R6 window user read");
    clr(); req_vaddr = SPW | 64'h40; cur_mode = 1; req_kind = 2; go("R6 window exec write");
    clr(); req_vaddr = SPW | 64'h40; cur_mode = 2; req_kind = 0; go("R6 window super fetch");

    // R7 miss
    clr(); req_vaddr = 64'h4000; go("R7 read miss");
    clr(); req_vaddr = 64'h4000; req_kind = 2; req_ptacc = 1; go("R7 write miss pte");
    clr(); req_vaddr = 64'h4000; req_kind = 0; go("R7 fetch miss");

    // R8 hit composition and lookup port
    clr(); req_vaddr = 64'h0000_0000_2001_ABC8; cur_asn = 8'h5A;
    set_tlb(1, 32'h55, 4'hF, 4'hF, 0, 0);
    req_valid = 1; #1;
    n_checks++;
    if (tlb_lookup !== 1'b1 || tlb_vpn !== 51'(req_vaddr >> 13) || tlb_asn !== 8'h5A) begin
      n_fail++;
      $display("FAIL R8 lookup port: got lk=%b vpn=%h asn=%h expected 1 %h 5a",
               tlb_lookup, tlb_vpn, tlb_asn, 51'(req_vaddr >> 13));
    end
    go("R8 read hit");
    clr(); req_vaddr = 64'h0000_0000_2001_ABCF; req_kind = 0; req_size = 1;
    set_tlb(1, 32'h55, 4'hF, 4'hF, 0, 0); go("R8 fetch hit clears low bits");

    // R9 write permissions
    clr(); req_kind = 2; req_vaddr = 64'h6000; cur_mode = 2;
    set_tlb(1, 32'h7, 4'hF, 4'b1011, 0, 1); go("R9 write denied with fonw");
    clr(); req_kind = 2; req_vaddr = 64'h6000; cur_mode = 2;
    set_tlb(1, 32'h7, 4'hF, 4'b1011, 0, 0); go("R9 write denied");
    clr(); req_kind = 2; req_vaddr = 64'h6000; cur_mode = 2;
    set_tlb(1, 32'h7, 4'hF, 4'b0100, 0, 1); go("R9 write fonw only");
    clr(); req_kind = 2; req_vaddr = 64'h6000; cur_mode = 2;
    set_tlb(1, 32'h7, 4'hF, 4'b0100, 1, 0); go("R9 write allowed");

    // R10 read / fetch permissions
    clr(); req_vaddr = 64'h6008; cur_mode = 1;
    set_tlb(1, 32'h9, 4'b1101, 4'hF, 1, 0); go("R10 read denied with fonr");
    clr(); req_vaddr = 64'h6008; cur_mode = 1;
    set_tlb(1, 32'h9, 4'b0010, 4'hF, 1, 1); go("R10 read fonr only");
    clr(); req_vaddr = 64'h6008; cur_mode = 1; req_kind = 0;
    set_tlb(1, 32'h9, 4'b0010, 4'h0, 1, 1); go("R10 fetch ignores fon");
    clr(); req_vaddr = 64'h6008; cur_mode = 1; req_kind = 0;
    set_tlb(1, 32'h9, 4'b1101, 4'hF, 0, 0); go("R10 fetch denied");

    // R11 range
    clr(); req_phys = 1; req_vaddr = 64'h0004_0000_0000_0000; go("R11 physical out of range");
    clr(); req_vaddr = 64'h6000; set_tlb(1, 32'h8000_0001, 4'hF, 4'hF, 0, 0); go("R11 hit out of range");

    // R12 uncached region
    clr(); req_phys = 1; req_vaddr = 64'h0000_0A5F_F000_1234; go("R12 uncached strip");
    clr(); req_phys = 1; req_vaddr = 64'h0000_0E00_0000_0040; go("R12 register space");
    clr(); req_phys = 1; req_kind = 0; req_vaddr = 64'h0000_0800_0000_0040; go("R12 uncached fetch");
    clr(); req_vaddr = 64'h6010; set_tlb(1, 32'h4FF0_0001, 4'hF, 4'hF, 0, 0); go("R12 hit uncached");

    // mixed random traffic (R1..R12)
    for (int i = 0; i < 300; i++) begin
      int sel;
      clr();
      sel = $urandom_range(0, 3);
      req_vaddr = {$urandom, $urandom};
      case (sel)
        0: req_vaddr = req_vaddr & 64'h0000_03FF_FFFF_FFFF;
        1: req_vaddr = SPW | (req_vaddr & 64'h0001_FFFF_FFFF_FFF8);
        2: req_vaddr = req_vaddr;
        default: req_vaddr = req_vaddr & 64'h0000_0FFF_FFFF_FFFF;
      endcase
      req_size    = 4'(1 << $urandom_range(0, 3));
      req_kind    = 2'($urandom_range(0, 2));
      req_phys    = ($urandom_range(0, 3) == 0);
      req_ptacc   = 1'($urandom);
      req_alt     = 1'($urandom);
      req_priv_pc = ($urandom_range(0, 4) == 0);
      cur_mode    = 2'($urandom);
      alt_mode    = 2'($urandom);
      set_tlb(($urandom_range(0, 4) != 0), $urandom, 4'($urandom), 4'($urandom),
              ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
      go("R1-mix random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule